// File: doc/BRIEF.md
# Four-Stage Universal Shift Register with J / K-bar Entry

This block is a small clocked register of four stages that either captures a parallel word in one clock or moves its contents one stage toward the last stage on each clock. An active-low mode input picks between the two behaviours. In shifting mode the first stage is fed by a J input and an inverted-sense K input. That pair can clear, set, keep or invert the bit that currently sits in the first stage.

An active-low master reset empties every stage at once, without waiting for the clock. Besides the four stage values, the block presents the complement of the last stage on its own pin. Tying J and K-bar together makes the entry behave as a plain serial data input. The block suits serial-to-parallel and parallel-to-serial conversion, small counters and pattern generators.

Top module: `univ_shift_reg`

## Requirements
- R1: Stage values change only on a rising clock edge (or by reset); a falling edge, or a change of inputs between edges, leaves them unchanged.
- R2: When `parLoadN` is 0 at a rising edge, `stageQ[i]` takes `parIn[i]` for every i, whatever `jIn` and `kInN` are.
- R3: When `parLoadN` is 1 at a rising edge, `stageQ[i]` takes the old `stageQ[i-1]` for i = 1..3, and the old `stageQ[3]` is lost.
- R4: In shift mode with `jIn`=0 and `kInN`=0, `stageQ[0]` becomes 0.
- R5: In shift mode with `jIn`=1 and `kInN`=1, `stageQ[0]` becomes 1.
- R6: In shift mode with `jIn`=0 and `kInN`=1, `stageQ[0]` keeps its previous value.
- R7: In shift mode with `jIn`=1 and `kInN`=0, `stageQ[0]` becomes the inverse of its previous value.
- R8: A 0 on `rstN` drives all four stages to 0 at once, before any further clock edge.
- R9: Rising edges that arrive while `rstN` is 0 have no effect; the first rising edge after `rstN` returns to 1 loads or shifts normally.
- R10: `lastQN` always equals the inverse of `stageQ[3]`, and so reads 1 after reset.
- R11: With `jIn` and `kInN` driven by the same bit in shift mode, `stageQ[0]` takes that bit on each edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all transfers occur on its rising edge |
| rstN | input | 1 | Asynchronous master reset, active low |
| parLoadN | input | 1 | Mode select: 0 = parallel load, 1 = shift toward last stage |
| jIn | input | 1 | J entry for the first stage, active high |
| kInN | input | 1 | K entry for the first stage, active low |
| parIn | input | 4 | Parallel word; bit 0 feeds the first stage |
| stageQ | output | 4 | Stage contents; bit 0 is the first stage, bit 3 the last |
| lastQN | output | 1 | Complement of the last stage |

## Verification
Two functions can meet in one cycle. The asynchronous reset can drop in the middle of a cycle while a load or shift is already set up for the next edge. Reset release can also be followed by an edge that carries a load. The bench lowers `rstN` between edges with a full load pending, and it checks the stages and `lastQN` before the next edge arrives. It then clocks with reset held, releases reset between edges and judges that only the first edge after release changes the stages.

// File: rtl/usr_pkg.sv
package usr_pkg;

  // Strobes passed from the mode/entry decoder to the stage datapath.
  typedef struct packed {
    logic loadPar;   // capture the parallel word on the next edge
    logic shiftEn;   // move stages one place toward the last stage
    logic entryBit;  // value the first stage takes when shifting
  } usrStrobes_t;

endpackage

// File: rtl/usr_ctrl.sv
module usr_ctrl
  import usr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        parLoadN,
  input  logic        jIn,
  input  logic        kInN,
  input  logic        firstQ,
  output usrStrobes_t strobes
);

  logic setTerm;
  logic keepTerm;

  // J sets a cleared stage, K-bar keeps a set stage.
  assign setTerm  = jIn & ~firstQ;
  assign keepTerm = kInN & firstQ;

  always_comb begin
    strobes          = '0;
    strobes.loadPar  = ~parLoadN;
    strobes.shiftEn  = parLoadN;
    strobes.entryBit = setTerm | keepTerm;
  end

  // Entry behaviour, judged on the first stage one edge later.
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (parLoadN && !jIn && !kInN) |=> !firstQ);

  assert_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    (parLoadN && jIn && kInN) |=> firstQ);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (parLoadN && !jIn && kInN) |=> $stable(firstQ));

  assert_toggle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (parLoadN && jIn && !kInN) |=> (firstQ != $past(firstQ)));

endmodule

// File: rtl/usr_dpath.sv
module usr_dpath
  import usr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  usrStrobes_t      strobes,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] stageQ,
  output logic             lastQN
);

  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] stageNext;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_stage
      logic shiftSrc;
      if (gi == 0) begin : g_first
        assign shiftSrc = strobes.entryBit;
      end else begin : g_follow
        assign shiftSrc = stageQ[gi-1];
      end

      always_comb begin
        if (strobes.loadPar)      stageNext[gi] = parIn[gi];
        else if (strobes.shiftEn) stageNext[gi] = shiftSrc;
        else                      stageNext[gi] = stageQ[gi];
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[gi] <= 1'b0;
        else       stageQ[gi] <= stageNext[gi];
      end
    end
  endgenerate

  assign lastQN = ~stageQ[LAST];

  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadPar |=> (stageQ == $past(parIn)));

  assert_shift_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shiftEn |=> (stageQ[LAST:1] == $past(stageQ[LAST-1:0])));

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.loadPar && strobes.shiftEn));

endmodule

// File: rtl/univ_shift_reg.sv
module univ_shift_reg
  import usr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             parLoadN,
  input  logic             jIn,
  input  logic             kInN,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] stageQ,
  output logic             lastQN
);

  usrStrobes_t strobes;

  usr_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .parLoadN (parLoadN),
    .jIn      (jIn),
    .kInN     (kInN),
    .firstQ   (stageQ[0]),
    .strobes  (strobes)
  );

  usr_dpath #(.WIDTH(WIDTH)) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .parIn   (parIn),
    .stageQ  (stageQ),
    .lastQN  (lastQN)
  );

endmodule

// File: tb/univ_shift_reg_tb.sv
`timescale 1ns/1ps
module univ_shift_reg_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       parLoadN;
  logic       jIn;
  logic       kInN;
  logic [3:0] parIn;
  logic [3:0] stageQ;
  logic       lastQN;

  int nChecks = 0;
  int nFails  = 0;
  logic [3:0] expQ;

  always #2.5 clk = ~clk;

  univ_shift_reg dut_i (
    .clk(clk), .rstN(rstN), .parLoadN(parLoadN), .jIn(jIn), .kInN(kInN),
    .parIn(parIn), .stageQ(stageQ), .lastQN(lastQN)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkAll(input string req);
    check(req, stageQ, expQ);
    check("R10", {3'b0, lastQN}, {3'b0, ~expQ[3]});
  endtask

  // One rising edge, then sample 1 ns later (well before the falling edge).
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic shiftModel(input logic j, input logic kn);
    logic nb;
    nb = (j & ~expQ[0]) | (kn & expQ[0]);
    expQ = {expQ[2:0], nb};
  endtask

  task automatic testReset();
    // R8, R10: reset state
    rstN = 1'b0; parLoadN = 1'b0; parIn = 4'hF; jIn = 1'b1; kInN = 1'b1;
    #1;
    expQ = 4'h0;
    checkAll("R8");
    // R9: edges during reset do nothing
    step(); step();
    checkAll("R9");
    rstN = 1'b1;              // release between edges
    #0.5;
    checkAll("R9");
    step();                   // first edge after release loads
    expQ = 4'hF;
    checkAll("R9");
  endtask

  task automatic testLoad();
    // R2: load with each J/K-bar combination
    parLoadN = 1'b0;
    for (int c = 0; c < 4; c++) begin
      jIn = c[0]; kInN = c[1];
      parIn = 4'(4'h5 + c * 3);
      step();
      expQ = parIn;
      checkAll("R2");
    end
  endtask

  task automatic testShift();
    // R3: shift, old last stage dropped
    parLoadN = 1'b0; parIn = 4'b1001; step(); expQ = 4'b1001; checkAll("R2");
    parLoadN = 1'b1; jIn = 1'b0; kInN = 1'b0;
    step(); expQ = 4'b0010; checkAll("R3");
    step(); expQ = 4'b0100; checkAll("R3");
  endtask

  task automatic testJk();
    parLoadN = 1'b0; parIn = 4'b0001; step(); expQ = 4'b0001;
    parLoadN = 1'b1;
    jIn = 1'b0; kInN = 1'b0; step(); shiftModel(1'b0, 1'b0);
    checkAll("R4"); check("R4", {3'b0, stageQ[0]}, 4'b0);
    jIn = 1'b1; kInN = 1'b1; step(); shiftModel(1'b1, 1'b1);
    checkAll("R5"); check("R5", {3'b0, stageQ[0]}, 4'b1);
    jIn = 1'b0; kInN = 1'b1; step(); shiftModel(1'b0, 1'b1);
    checkAll("R6"); check("R6", {3'b0, stageQ[0]}, 4'b1);
    jIn = 1'b1; kInN = 1'b0; step(); shiftModel(1'b1, 1'b0);
    checkAll("R7"); check("R7", {3'b0, stageQ[0]}, 4'b0);
    step(); shiftModel(1'b1, 1'b0);
    checkAll("R7"); check("R7", {3'b0, stageQ[0]}, 4'b1);
    jIn = 1'b0; kInN = 1'b1; step(); shiftModel(1'b0, 1'b1);
    checkAll("R6"); check("R6", {3'b0, stageQ[0]}, 4'b1);
  endtask

  task automatic testDmode();
    // R11: J tied to K-bar acts as serial data
    logic [7:0] pat;
    pat = 8'b1011_0010;
    parLoadN = 1'b1;
    for (int i = 0; i < 8; i++) begin
      jIn = pat[i]; kInN = pat[i];
      step();
      expQ = {expQ[2:0], pat[i]};
      checkAll("R11");
    end
  endtask

  task automatic testEdgeOnly();
    // R1: input changes and falling edges alter nothing
    parLoadN = 1'b0; parIn = 4'b0110; step(); expQ = 4'b0110;
    parIn = 4'b1001; jIn = 1'b1; kInN = 1'b0;
    @(negedge clk); #0.5;
    checkAll("R1");
    parLoadN = 1'b1;
    #0.5;
    checkAll("R1");
    step(); shiftModel(1'b1, 1'b0);
    checkAll("R1");
  endtask

  task automatic testMidReset();
    // R8: reset lands mid-cycle with a load pending
    parLoadN = 1'b0; parIn = 4'b1111; step(); expQ = 4'hF; checkAll("R2");
    parIn = 4'b1010;
    #0.5;
    rstN = 1'b0;
    #0.3;
    expQ = 4'h0;
    checkAll("R8");
    step();
    checkAll("R9");
    rstN = 1'b1;
    step(); expQ = 4'b1010;
    checkAll("R9");
  endtask

  initial begin
    testReset();
    testLoad();
    testShift();
    testJk();
    testDmode();
    testEdgeOnly();
    testMidReset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #100000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule